// File: doc/BRIEF.md
# Pipeline Hazard Forwarding and Stall Unit

This block is the hazard control logic of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). It compares the two source register identifiers of the instruction in decode against the destination identifiers and write enables of the instructions in execute, memory and writeback. From that comparison it produces, for each decode operand, a select that tells the operand multiplexer where to take the value from. It also produces hold signals for the fetch and decode registers and a bubble request that turns the execute-stage input into a no-op.

The unit is purely combinational and has no clock. A parameter picks one of two policies. In forwarding mode, any value still in flight is bypassed from the youngest stage that holds it. A load in execute that feeds the decode instruction costs exactly one held cycle. After that cycle the loaded value is taken from the memory-stage output. In stall-only mode nothing is bypassed. The dependent instruction waits in decode until every producer of its sources has left writeback.

Top module: `hazard_unit`

## Requirements
- R1: In forwarding mode, an operand whose source equals the execute destination, with the execute write enable high, selects the execute result. The select encoding is 0 = register file, 1 = execute result, 2 = memory-stage result, 3 = writeback result.
- R2: Matching is done per register identifier. A producer that writes a different register, or that has its write enable low, causes neither forwarding nor a stall.
- R3: Operand A and operand B are each compared against all three stages on their own, and each gets its own select.
- R4: In forwarding mode, a load in execute whose destination is read by decode raises a stall for exactly that cycle. On the next cycle the load sits in memory, and the operand selects 2 (memory-stage result) with no stall.
- R5: In stall-only mode, both selects are always 0. Decode is stalled while any operand source matches a written destination in execute, memory or writeback. A dependent instruction that directly follows its producer is therefore held for three cycles.
- R6: The fetch stall always equals the decode stall, so the instruction behind a held one is held too.
- R7: Register identifier 15 (all ones) means no register. A source of 15 never matches, even against a destination of 15 with its write enable high.
- R8: When several stages write a register that an operand reads, the select goes to execute first, then memory, then writeback.
- R9: The execute bubble is high exactly when decode is stalled. While a stall is raised, both selects are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a_id | input | 4 | First source register of the decode instruction |
| src_b_id | input | 4 | Second source register of the decode instruction |
| ex_dst_id | input | 4 | Destination register of the execute instruction |
| ex_wr_en | input | 1 | Execute instruction writes its destination |
| ex_is_load | input | 1 | Execute instruction is a load |
| mem_dst_id | input | 4 | Destination register of the memory-stage instruction |
| mem_wr_en | input | 1 | Memory-stage instruction writes its destination |
| wb_dst_id | input | 4 | Destination register of the writeback instruction |
| wb_wr_en | input | 1 | Writeback instruction writes its destination |
| fwd_a_sel | output | 2 | Operand A source select |
| fwd_b_sel | output | 2 | Operand B source select |
| stall_fetch | output | 1 | Hold the fetch register |
| stall_decode | output | 1 | Hold the decode register |
| bubble_exec | output | 1 | Load a no-op into execute |

## Verification
Both policies are swept at the same time over every combination of four register identifiers (0, 1, 2 and the no-register code 15) on the five identifier inputs, crossed with all sixteen settings of the three write enables and the load flag. Equal identifiers against differing ones tell true dependences apart from look-alike producers. Identifiers that repeat across stages expose the execute-over-memory-over-writeback ordering. The no-register code against itself separates a real match from the sentinel. Short hand-stepped producer and consumer sequences then count the held cycles: one for a load in forwarding mode, followed by a memory-stage select, and three in stall-only mode.

// File: rtl/hzu_pkg.sv
package hzu_pkg;
    typedef enum logic [1:0] {
        SEL_RF  = 2'd0,
        SEL_EX  = 2'd1,
        SEL_MEM = 2'd2,
        SEL_WB  = 2'd3
    } fwd_sel_e;

    localparam int NUM_SRC = 2;
endpackage

// File: rtl/hzu_operand_fwd.sv
module hzu_operand_fwd
    import hzu_pkg::*;
#(
    parameter int REG_W  = 4,
    parameter bit FWD_EN = 1'b1
) (
    input  logic [REG_W-1:0] src_id,
    input  logic [REG_W-1:0] ex_dst_id,
    input  logic             ex_wr_en,
    input  logic [REG_W-1:0] mem_dst_id,
    input  logic             mem_wr_en,
    input  logic [REG_W-1:0] wb_dst_id,
    input  logic             wb_wr_en,
    output logic [1:0]       raw_sel,
    output logic             hit_ex,
    output logic             hit_any
);
    localparam logic [REG_W-1:0] NO_REG = '1;

    typedef struct packed {
        logic     hit_ex;
        logic     hit_mem;
        logic     hit_wb;
        fwd_sel_e sel;
    } op_t;

    op_t op_d;

    always_comb begin
        op_d         = '0;
        op_d.sel     = SEL_RF;
        if (src_id != NO_REG) begin
            op_d.hit_ex  = ex_wr_en  && (ex_dst_id  == src_id);
            op_d.hit_mem = mem_wr_en && (mem_dst_id == src_id);
            op_d.hit_wb  = wb_wr_en  && (wb_dst_id  == src_id);
        end
        if (FWD_EN) begin
            if (op_d.hit_ex)       op_d.sel = SEL_EX;
            else if (op_d.hit_mem) op_d.sel = SEL_MEM;
            else if (op_d.hit_wb)  op_d.sel = SEL_WB;
        end
    end

    assign raw_sel = op_d.sel;
    assign hit_ex  = op_d.hit_ex;
    assign hit_any = op_d.hit_ex | op_d.hit_mem | op_d.hit_wb;

    always_comb begin
        // R7: the sentinel identifier never produces a hit
        assert_no_reg_match_R7: assert ((src_id != NO_REG) || (!hit_any && raw_sel == 2'd0))
            else $error("no-register source matched");
        // R1: an execute select implies a genuine execute producer
        assert_ex_sel_valid_R1: assert ((raw_sel != 2'd1) || (ex_wr_en && ex_dst_id == src_id))
            else $error("execute select without execute producer");
        // R8: memory select only when execute does not write this register
        assert_mem_below_ex_R8: assert ((raw_sel != 2'd2) || !(ex_wr_en && ex_dst_id == src_id))
            else $error("memory select shadowed an execute producer");
        // R5: stall-only mode never bypasses
        assert_no_bypass_R5: assert (FWD_EN || raw_sel == 2'd0)
            else $error("bypass in stall-only mode");
    end
endmodule

// File: rtl/hzu_stall_ctl.sv
module hzu_stall_ctl #(
    parameter bit FWD_EN = 1'b1
) (
    input  logic ex_is_load,
    input  logic hit_ex_a,
    input  logic hit_ex_b,
    input  logic hit_any_a,
    input  logic hit_any_b,
    output logic stall_fetch,
    output logic stall_decode,
    output logic bubble_exec
);
    typedef struct packed {
        logic hold_f;
        logic hold_d;
        logic bubble;
    } ctl_t;

    ctl_t ctl_d;

    always_comb begin
        ctl_d = '0;
        if (FWD_EN) ctl_d.hold_d = ex_is_load && (hit_ex_a || hit_ex_b);
        else        ctl_d.hold_d = hit_any_a || hit_any_b;
        ctl_d.hold_f = ctl_d.hold_d;
        ctl_d.bubble = ctl_d.hold_d;
    end

    assign stall_fetch  = ctl_d.hold_f;
    assign stall_decode = ctl_d.hold_d;
    assign bubble_exec  = ctl_d.bubble;

    always_comb begin
        // R4: a load feeding decode must hold it
        assert_load_use_stall_R4: assert (!(FWD_EN && ex_is_load && (hit_ex_a || hit_ex_b)) || stall_decode)
            else $error("load-use hazard without stall");
        // R2: no dependence anywhere means no stall
        assert_no_false_stall_R2: assert ((hit_any_a || hit_any_b) || !stall_decode)
            else $error("stall without any dependence");
        // R6: fetch is held together with decode
        assert_fetch_with_decode_R6: assert (stall_fetch == stall_decode)
            else $error("fetch and decode stalls differ");
    end
endmodule

// File: rtl/hazard_unit.sv
module hazard_unit
    import hzu_pkg::*;
#(
    parameter int REG_W  = 4,
    parameter bit FWD_EN = 1'b1
) (
    input  logic [REG_W-1:0] src_a_id,
    input  logic [REG_W-1:0] src_b_id,
    input  logic [REG_W-1:0] ex_dst_id,
    input  logic             ex_wr_en,
    input  logic             ex_is_load,
    input  logic [REG_W-1:0] mem_dst_id,
    input  logic             mem_wr_en,
    input  logic [REG_W-1:0] wb_dst_id,
    input  logic             wb_wr_en,
    output logic [1:0]       fwd_a_sel,
    output logic [1:0]       fwd_b_sel,
    output logic             stall_fetch,
    output logic             stall_decode,
    output logic             bubble_exec
);
    logic [REG_W-1:0] src_vec  [NUM_SRC];
    logic [1:0]       raw_sel  [NUM_SRC];
    logic             hit_ex   [NUM_SRC];
    logic             hit_any  [NUM_SRC];
    logic [1:0]       sel_d    [NUM_SRC];

    assign src_vec[0] = src_a_id;
    assign src_vec[1] = src_b_id;

    // R3: one independent comparator per decode operand
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_operand
        hzu_operand_fwd #(
            .REG_W  (REG_W),
            .FWD_EN (FWD_EN)
        ) u_op (
            .src_id     (src_vec[g]),
            .ex_dst_id  (ex_dst_id),
            .ex_wr_en   (ex_wr_en),
            .mem_dst_id (mem_dst_id),
            .mem_wr_en  (mem_wr_en),
            .wb_dst_id  (wb_dst_id),
            .wb_wr_en   (wb_wr_en),
            .raw_sel    (raw_sel[g]),
            .hit_ex     (hit_ex[g]),
            .hit_any    (hit_any[g])
        );
        assign sel_d[g] = stall_decode ? SEL_RF : raw_sel[g];
    end

    hzu_stall_ctl #(
        .FWD_EN (FWD_EN)
    ) u_stall (
        .ex_is_load   (ex_is_load),
        .hit_ex_a     (hit_ex[0]),
        .hit_ex_b     (hit_ex[1]),
        .hit_any_a    (hit_any[0]),
        .hit_any_b    (hit_any[1]),
        .stall_fetch  (stall_fetch),
        .stall_decode (stall_decode),
        .bubble_exec  (bubble_exec)
    );

    assign fwd_a_sel = sel_d[0];
    assign fwd_b_sel = sel_d[1];

    always_comb begin
        // R9: a held decode instruction consumes no bypassed value
        assert_stall_sel_rf_R9: assert (!bubble_exec || (fwd_a_sel == 2'd0 && fwd_b_sel == 2'd0))
            else $error("bypass select during stall");
    end
endmodule

// File: tb/tb_hazard_unit.sv
module tb_hazard_unit;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic [3:0] src_a, src_b, e_dst, m_dst, w_dst;
    logic       e_we, e_ld, m_we, w_we;

    logic [1:0] fa_f, fb_f, fa_s, fb_s;
    logic       sf_f, sd_f, be_f, sf_s, sd_s, be_s;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    hazard_unit #(.REG_W(4), .FWD_EN(1'b1)) dut (
        .src_a_id(src_a), .src_b_id(src_b),
        .ex_dst_id(e_dst), .ex_wr_en(e_we), .ex_is_load(e_ld),
        .mem_dst_id(m_dst), .mem_wr_en(m_we),
        .wb_dst_id(w_dst), .wb_wr_en(w_we),
        .fwd_a_sel(fa_f), .fwd_b_sel(fb_f),
        .stall_fetch(sf_f), .stall_decode(sd_f), .bubble_exec(be_f));

    hazard_unit #(.REG_W(4), .FWD_EN(1'b0)) dut_stall (
        .src_a_id(src_a), .src_b_id(src_b),
        .ex_dst_id(e_dst), .ex_wr_en(e_we), .ex_is_load(e_ld),
        .mem_dst_id(m_dst), .mem_wr_en(m_we),
        .wb_dst_id(w_dst), .wb_wr_en(w_we),
        .fwd_a_sel(fa_s), .fwd_b_sel(fb_s),
        .stall_fetch(sf_s), .stall_decode(sd_s), .bubble_exec(be_s));

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (a=%0d b=%0d e=%0d/%0b/%0b m=%0d/%0b w=%0d/%0b)",
                     tag, act, exp, src_a, src_b, e_dst, e_we, e_ld, m_dst, m_we, w_dst, w_we);
        end
    endtask

    function automatic bit hit(input logic [3:0] s, input logic [3:0] d, input logic we);
        return (s != 4'hF) && we && (s == d);
    endfunction

    function automatic int sel_of(input logic [3:0] s);
        if (hit(s, e_dst, e_we)) return 1;
        if (hit(s, m_dst, m_we)) return 2;
        if (hit(s, w_dst, w_we)) return 3;
        return 0;
    endfunction

    function automatic bit any_hit(input logic [3:0] s);
        return hit(s, e_dst, e_we) || hit(s, m_dst, m_we) || hit(s, w_dst, w_we);
    endfunction

    task automatic drive(input logic [3:0] a, input logic [3:0] b,
                         input logic [3:0] ed, input logic ew, input logic el,
                         input logic [3:0] md, input logic mw,
                         input logic [3:0] wd, input logic ww);
        @(posedge clk);
        src_a = a; src_b = b; e_dst = ed; e_we = ew; e_ld = el;
        m_dst = md; m_we = mw; w_dst = wd; w_we = ww;
        @(negedge clk);
    endtask

    task automatic sweep_check();
        bit lu, st_f, st_s;
        lu   = e_ld && (hit(src_a, e_dst, e_we) || hit(src_b, e_dst, e_we));
        st_f = lu;                                   // R4
        st_s = any_hit(src_a) || any_hit(src_b);     // R5
        // R1 R2 R3 R7 R8 operand selects, R9 forced to 0 under stall
        chk("R1 R3 R8 fwd mode sel A", fa_f, st_f ? 0 : sel_of(src_a));
        chk("R1 R3 R8 fwd mode sel B", fb_f, st_f ? 0 : sel_of(src_b));
        chk("R4 fwd mode stall",       sd_f, st_f);
        chk("R6 fwd mode fetch stall", sf_f, st_f);
        chk("R9 fwd mode bubble",      be_f, st_f);
        chk("R5 stall mode sel A",     fa_s, 0);
        chk("R5 stall mode sel B",     fb_s, 0);
        chk("R5 stall mode stall",     sd_s, st_s);
        chk("R6 stall mode fetch",     sf_s, st_s);
        chk("R9 stall mode bubble",    be_s, st_s);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [3:0] ids [4];
        int ns;
        ids[0] = 4'd0; ids[1] = 4'd1; ids[2] = 4'd2; ids[3] = 4'hF;

        // Idle state: nothing in flight
        drive(4'd0, 4'd1, 4'd0, 1'b0, 1'b0, 4'd1, 1'b0, 4'd0, 1'b0);
        chk("R2 idle sel A", fa_f, 0);
        chk("R2 idle sel B", fb_f, 0);
        chk("R2 idle stall", sd_f, 0);
        chk("R2 idle stall-only stall", sd_s, 0);

        // R7: sentinel against sentinel on every stage
        drive(4'hF, 4'hF, 4'hF, 1'b1, 1'b1, 4'hF, 1'b1, 4'hF, 1'b1);
        chk("R7 sentinel sel A", fa_f, 0);
        chk("R7 sentinel stall fwd", sd_f, 0);
        chk("R7 sentinel stall only", sd_s, 0);

        // R2: producer writes rbx(3), consumer reads rax(0)
        drive(4'd0, 4'd0, 4'd3, 1'b1, 1'b1, 4'd3, 1'b1, 4'd3, 1'b1);
        chk("R2 other reg no stall", sd_f, 0);
        chk("R2 other reg sel", fa_f, 0);

        // R4: load to r0 in execute, consumer reads r0 -> one held cycle
        ns = 0;
        drive(4'd0, 4'd5, 4'd0, 1'b1, 1'b1, 4'd9, 1'b0, 4'd9, 1'b0);
        if (sd_f) ns++;
        chk("R4 load-use stall raised", sd_f, 1);
        // load moves to memory, bubble in execute
        drive(4'd0, 4'd5, 4'd0, 1'b0, 1'b0, 4'd0, 1'b1, 4'd9, 1'b0);
        if (sd_f) ns++;
        chk("R4 memory select after stall", fa_f, 2);
        chk("R4 load-use stall count", ns, 1);

        // R5: stall-only, producer of r0 travels E, M, W
        ns = 0;
        drive(4'd4, 4'd0, 4'd0, 1'b1, 1'b0, 4'd9, 1'b0, 4'd9, 1'b0);
        if (sd_s) ns++;
        drive(4'd4, 4'd0, 4'd0, 1'b0, 1'b0, 4'd0, 1'b1, 4'd9, 1'b0);
        if (sd_s) ns++;
        drive(4'd4, 4'd0, 4'd0, 1'b0, 1'b0, 4'd0, 1'b0, 4'd0, 1'b1);
        if (sd_s) ns++;
        drive(4'd4, 4'd0, 4'd0, 1'b0, 1'b0, 4'd0, 1'b0, 4'd0, 1'b0);
        if (sd_s) ns++;
        chk("R5 stall-only held cycles", ns, 3);

        // R8: r1 written by all three stages
        drive(4'd1, 4'd2, 4'd1, 1'b1, 1'b0, 4'd1, 1'b1, 4'd1, 1'b1);
        chk("R8 execute wins", fa_f, 1);
        drive(4'd1, 4'd2, 4'd1, 1'b0, 1'b0, 4'd1, 1'b1, 4'd1, 1'b1);
        chk("R8 memory over writeback", fa_f, 2);

        // Near-exhaustive sweep
        for (int ia = 0; ia < 4; ia++)
            for (int ib = 0; ib < 4; ib++)
                for (int ie = 0; ie < 4; ie++)
                    for (int im = 0; im < 4; im++)
                        for (int iw = 0; iw < 4; iw++)
                            for (int fl = 0; fl < 16; fl++) begin
                                drive(ids[ia], ids[ib], ids[ie], fl[0], fl[3],
                                      ids[im], fl[1], ids[iw], fl[2]);
                                sweep_check();
                            end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule